// File: doc/BRIEF.md
# Two-Thread Decode Slot Priority Arbiter

This block shares one instruction decode frontend between two hardware threads, one slot per cycle. Each thread holds a priority level. A thread changes its own level in-band by issuing an OR instruction that names the same register as destination and both sources. The instruction has no architectural effect, but the block reads its register number as a priority request. A per-thread monitor watches the stream of decoded words, recognises these hint encodings, applies the rule that some levels need kernel mode, and updates that thread's level register.

A scheduler hands out the decode slot each cycle. If neither thread is runnable, no slot is granted. If one thread is runnable, it gets every slot. If both are runnable, a 16-position window splits the slots in a weighted round-robin, and the weights come from the two levels. The hint inputs form a data stream with a valid qualifier and no ready. The monitor accepts a word in every cycle its valid is high and never applies back-pressure, so the upstream decoder does not need to hold a word. Runnable flags, kernel flags, the grant and the levels are plain level signals.

Top module: `smt_issue_arbiter`

## Requirements
- R1: A word is a hint only when all of these hold: bits [31:26] = 31, bits [10:1] = 444, bit 0 = 0, and the three 5-bit register fields at [25:21], [20:16] and [15:11] are equal.
- R2: In either mode, a hint naming register 1 sets level 2 (low), register 6 sets level 3 (medium-low), and register 2 sets level 4 (normal).
- R3: A hint naming register 31 sets level 1, register 5 sets level 5, and register 3 sets level 6, but only while that thread's kernel flag is high. In user mode these hints leave the level unchanged.
- R4: The following leave the level unchanged: a word with bit 0 set, a word with unequal register fields, a word with a different opcode, a hint naming any other register, and a cycle with valid low.
- R5: A level change appears on `level_o` in the cycle after the hint is presented. Each thread's hint affects only that thread's level.
- R6: After reset both levels are 4 and the window position is 0.
- R7: With no thread runnable, `grant_o` is 0.
- R8: With exactly one thread runnable, that thread is granted every cycle, whatever the levels.
- R9: The window position advances by one (mod 16) only in cycles where both threads are runnable. When both are runnable at position c, thread 0 is granted if floor((c+1)·n/16) ≠ floor(c·n/16), and thread 1 is granted otherwise. Here n = 8 + b(level0) − b(level1), with b = {1:0, 2:2, 3:3, 4:4, 5:5, 6:7}. Over any 16 both-runnable cycles with unchanged levels, thread 0 therefore gets exactly n slots.
- R10: With equal levels, the grant alternates strictly between the threads. After reset, the first both-runnable slot goes to thread 1.
- R11: `grant_o` has at most one bit set, and never grants a thread whose runnable flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hint_valid_i | input | 2 | Per-thread valid for the hint word stream (bit t = thread t) |
| hint_word_i | input | 64 | Per-thread decoded word, thread t in bits [32t+31:32t] |
| kernel_i | input | 2 | Per-thread kernel mode flag |
| runnable_i | input | 2 | Per-thread runnable flag |
| grant_o | output | 2 | One-hot decode slot grant, combinational in the current cycle |
| level_o | output | 6 | Priority levels, thread t in bits [3t+2:3t] |

## Verification
The grant depends combinationally on the current runnable flags, the registered window position and the registered levels. The bench checks it in the same cycle the runnable flags are driven, one nanosecond after the falling edge. A hint takes effect through one register, so the bench updates its model levels at the rising edge that follows the hint and compares `level_o` from the next sample point on. It also checks that the old level is still present in the cycle the hint is presented. The window position in the model advances only after rising edges at which both runnable flags were high, which matches the single register step in the design.

// File: rtl/smt_arb_pkg.sv
package smt_arb_pkg;
  localparam int INSN_W = 32;
  localparam int LVL_W  = 3;
  localparam int REG_W  = 5;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_VLOW  = 3'd1;
  localparam lvl_t LVL_LOW   = 3'd2;
  localparam lvl_t LVL_MLOW  = 3'd3;
  localparam lvl_t LVL_NORM  = 3'd4;
  localparam lvl_t LVL_MHIGH = 3'd5;
  localparam lvl_t LVL_HIGH  = 3'd6;

  localparam logic [5:0] HINT_OPCD = 6'd31;
  localparam logic [9:0] HINT_XO   = 10'd444;

  // slot-share bias per level; thread 0 share = half window + b0 - b1
  function automatic logic [2:0] lvl_bias(input lvl_t l);
    case (l)
      3'd1:    lvl_bias = 3'd0;
      3'd2:    lvl_bias = 3'd2;
      3'd3:    lvl_bias = 3'd3;
      3'd4:    lvl_bias = 3'd4;
      3'd5:    lvl_bias = 3'd5;
      3'd6:    lvl_bias = 3'd7;
      default: lvl_bias = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/smt_hint_track.sv
module smt_hint_track
  import smt_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [INSN_W-1:0] word_i,
  input  logic              kernel_i,
  output lvl_t              level_o
);
  logic [5:0]       opcd;
  logic [REG_W-1:0] r_s, r_a, r_b;
  logic [9:0]       xo;
  logic             rc;
  logic             is_hint;
  logic             upd;
  lvl_t             lvl_q, lvl_new;

  assign opcd = word_i[31:26];
  assign r_s  = word_i[25:21];
  assign r_a  = word_i[20:16];
  assign r_b  = word_i[15:11];
  assign xo   = word_i[10:1];
  assign rc   = word_i[0];

  assign is_hint = valid_i && (opcd == HINT_OPCD) && (xo == HINT_XO) &&
                   !rc && (r_s == r_a) && (r_a == r_b);

  always_comb begin
    upd     = 1'b0;
    lvl_new = lvl_q;
    if (is_hint) begin
      case (r_s)
        5'd1:  begin upd = 1'b1;     lvl_new = LVL_LOW;   end
        5'd6:  begin upd = 1'b1;     lvl_new = LVL_MLOW;  end
        5'd2:  begin upd = 1'b1;     lvl_new = LVL_NORM;  end
        5'd31: begin upd = kernel_i; lvl_new = LVL_VLOW;  end
        5'd5:  begin upd = kernel_i; lvl_new = LVL_MHIGH; end
        5'd3:  begin upd = kernel_i; lvl_new = LVL_HIGH;  end
        default: upd = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   lvl_q <= LVL_NORM;
    else if (upd) lvl_q <= lvl_new;
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/smt_slot_sched.sv
module smt_slot_sched
  import smt_arb_pkg::*;
#(
  parameter int WIN_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] runnable_i,
  input  lvl_t       lvl0_i,
  input  lvl_t       lvl1_i,
  output logic [1:0] grant_o
);
  localparam int NW   = WIN_LOG2 + 1;
  localparam int PW   = 2 * NW;
  localparam int HALF = 1 << (WIN_LOG2 - 1);

  logic [WIN_LOG2-1:0] pos_q;
  logic [NW-1:0]       share0;
  logic [PW-1:0]       p_cur, p_nxt;
  logic                pick0;
  logic                both;

  assign both   = &runnable_i;
  assign share0 = NW'(HALF) + NW'(lvl_bias(lvl0_i)) - NW'(lvl_bias(lvl1_i));
  assign p_cur  = PW'(pos_q) * PW'(share0);
  assign p_nxt  = (PW'(pos_q) + PW'(1)) * PW'(share0);
  assign pick0  = (p_nxt >> WIN_LOG2) != (p_cur >> WIN_LOG2);

  always_comb begin
    case (runnable_i)
      2'b01:   grant_o = 2'b01;
      2'b10:   grant_o = 2'b10;
      2'b11:   grant_o = pick0 ? 2'b01 : 2'b10;
      default: grant_o = 2'b00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    pos_q <= '0;
    else if (both) pos_q <= pos_q + 1'b1;
  end
endmodule

// File: rtl/smt_issue_arbiter.sv
module smt_issue_arbiter
  import smt_arb_pkg::*;
#(
  parameter int WIN_LOG2 = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    hint_valid_i,
  input  logic [63:0]   hint_word_i,
  input  logic [1:0]    kernel_i,
  input  logic [1:0]    runnable_i,
  output logic [1:0]    grant_o,
  output logic [5:0]    level_o
);
  lvl_t lvl [2];

  for (genvar t = 0; t < 2; t++) begin : g_thr
    smt_hint_track u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (hint_valid_i[t]),
      .word_i   (hint_word_i[INSN_W*t +: INSN_W]),
      .kernel_i (kernel_i[t]),
      .level_o  (lvl[t])
    );
    assign level_o[LVL_W*t +: LVL_W] = lvl[t];
  end

  smt_slot_sched #(.WIN_LOG2(WIN_LOG2)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .runnable_i (runnable_i),
    .lvl0_i     (lvl[0]),
    .lvl1_i     (lvl[1]),
    .grant_o    (grant_o)
  );
endmodule

// File: rtl/smt_issue_arbiter_chk.sv
module smt_issue_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] hint_valid_i,
  input logic [1:0] runnable_i,
  input logic [1:0] grant_o,
  input logic [5:0] level_o
);
  logic seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R11
  AST_GRANT_RUNNABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~runnable_i) == 2'b00); // R11
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (runnable_i == 2'b00) |-> (grant_o == 2'b00)); // R7
  AST_SOLO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(runnable_i) == 1) |-> (grant_o == runnable_i)); // R8
  AST_BOTH_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (&runnable_i) |-> (grant_o != 2'b00)); // R9
  AST_EQUAL_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && (&runnable_i) && (level_o[2:0] == level_o[5:3]) &&
     $past(&runnable_i) && $past(level_o[2:0] == level_o[5:3]))
    |-> (grant_o != $past(grant_o))); // R10
  AST_LEVEL0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !$past(hint_valid_i[0])) |-> $stable(level_o[2:0])); // R5
  AST_LEVEL1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !$past(hint_valid_i[1])) |-> $stable(level_o[5:3])); // R5
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o[2:0] != 3'd0) && (level_o[2:0] != 3'd7) &&
    (level_o[5:3] != 3'd0) && (level_o[5:3] != 3'd7)); // R6
endmodule

bind smt_issue_arbiter smt_issue_arbiter_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hint_valid_i (hint_valid_i),
  .runnable_i   (runnable_i),
  .grant_o      (grant_o),
  .level_o      (level_o)
);

// File: tb/smt_issue_arbiter_tb.sv
`timescale 1ns/100ps
module smt_issue_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  hint_valid_i = '0;
  logic [63:0] hint_word_i = '0;
  logic [1:0]  kernel_i = '0;
  logic [1:0]  runnable_i = '0;
  logic [1:0]  grant_o;
  logic [5:0]  level_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int m_lvl [2];
  int m_pos;

  always #2.5 clk = ~clk;

  smt_issue_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .hint_valid_i(hint_valid_i), .hint_word_i(hint_word_i),
    .kernel_i(kernel_i), .runnable_i(runnable_i), .grant_o(grant_o), .level_o(level_o)
  );

  function automatic logic [31:0] hint(input int r);
    return {6'd31, r[4:0], r[4:0], r[4:0], 10'd444, 1'b0};
  endfunction

  function automatic int bias(input int l);
    case (l)
      1: return 0; 2: return 2; 3: return 3; 4: return 4; 5: return 5; 6: return 7;
      default: return 4;
    endcase
  endfunction

  function automatic int next_lvl(input int cur, input bit v, input logic [31:0] w, input bit k);
    if (!v || w[31:26] != 6'd31 || w[10:1] != 10'd444 || w[0] ||
        w[25:21] != w[20:16] || w[20:16] != w[15:11]) return cur;
    case (int'(w[25:21]))
      1: return 2; 6: return 3; 2: return 4;
      31: return k ? 1 : cur; 5: return k ? 5 : cur; 3: return k ? 6 : cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic [1:0] exp_grant(input logic [1:0] run, input int pos, input int l0, input int l1);
    int n;
    if (run != 2'b11) return run;
    n = 8 + bias(l0) - bias(l1);
    return (((pos + 1) * n) / 16 != (pos * n) / 16) ? 2'b01 : 2'b10;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive at falling edge, check 1 ns later, update model at the rising edge
  task automatic step(input logic [1:0] v, input logic [31:0] w0, input logic [31:0] w1,
                      input logic [1:0] k, input logic [1:0] run);
    logic [1:0] eg;
    string tg;
    @(negedge clk);
    hint_valid_i = v; hint_word_i = {w1, w0}; kernel_i = k; runnable_i = run;
    #1;
    eg = exp_grant(run, m_pos, m_lvl[0], m_lvl[1]);
    if (run == 2'b00) tg = "R7";
    else if (run != 2'b11) tg = "R8";
    else if (m_lvl[0] == m_lvl[1]) tg = "R10";
    else tg = "R9";
    chk(grant_o == eg, tg, grant_o, eg);
    chk((grant_o & ~run) == 2'b00, "R11", grant_o, run);
    chk(level_o == {3'(m_lvl[1]), 3'(m_lvl[0])}, "R5", level_o, {3'(m_lvl[1]), 3'(m_lvl[0])});
    @(posedge clk);
    m_lvl[0] = next_lvl(m_lvl[0], v[0], w0, k[0]);
    m_lvl[1] = next_lvl(m_lvl[1], v[1], w1, k[1]);
    if (run == 2'b11) m_pos = (m_pos + 1) % 16;
    #1;
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    m_lvl[0] = 4; m_lvl[1] = 4; m_pos = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R6: reset levels normal
    chk(level_o == 6'o44, "R6", level_o, 6'o44);
    chk(grant_o == 2'b00, "R7", grant_o, 0);
    // R10: first contested slot goes to thread 1, then strict alternation
    step(2'b00, 0, 0, 2'b00, 2'b11);
    step(2'b00, 0, 0, 2'b00, 2'b11);
    // R2: user-mode hint r1 -> low on thread 0, thread 1 untouched
    step(2'b01, hint(1), 0, 2'b00, 2'b01);
    chk(level_o == 6'o42, "R2", level_o, 6'o42);
    // R3: kernel-only hint in user mode ignored, then honoured in kernel
    step(2'b10, 0, hint(3), 2'b00, 2'b10);
    chk(level_o[5:3] == 3'd4, "R3", level_o[5:3], 4);
    step(2'b10, 0, hint(3), 2'b10, 2'b10);
    chk(level_o[5:3] == 3'd6, "R3", level_o[5:3], 6);
    // R4: recorded form, unequal fields, unassigned register
    step(2'b01, hint(6) | 32'h1, 0, 2'b01, 2'b00);
    chk(level_o[2:0] == 3'd2, "R4", level_o[2:0], 2);
    step(2'b01, hint(6) ^ 32'h0000_0800, 0, 2'b01, 2'b00);
    step(2'b01, hint(4), 0, 2'b01, 2'b00);
    chk(level_o[2:0] == 3'd2, "R4", level_o[2:0], 2);
    // R1: exact field layout recognised
    step(2'b01, {6'd31, 5'd6, 5'd6, 5'd6, 10'd444, 1'b0}, 0, 2'b00, 2'b00);
    chk(level_o[2:0] == 3'd3, "R1", level_o[2:0], 3);
    // R9: thread0 very low (1) vs thread1 high (6) -> thread 0 gets 1 of 16
    step(2'b11, hint(31), hint(3), 2'b11, 2'b00);
    cnt = 0;
    for (int i = 0; i < 16; i++) begin
      step(2'b00, 0, 0, 2'b00, 2'b11);
      if (grant_o == 2'b01) cnt++;
    end
    chk(cnt == 1, "R9", cnt, 1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w [2];
      logic [1:0] v, k, run;
      int regs [8] = '{1, 6, 2, 31, 5, 3, 4, 0};
      for (int t = 0; t < 2; t++) begin
        w[t] = hint(regs[$urandom_range(7)]);
        case ($urandom_range(5))
          0: w[t] = w[t] | 32'h1;
          1: w[t] = w[t] ^ (32'h1 << (11 + $urandom_range(14)));
          2: w[t] = $urandom;
          default: ;
        endcase
      end
      v = 2'($urandom_range(3)) & 2'($urandom_range(3));
      k = 2'($urandom_range(3));
      run = ($urandom_range(3) == 0) ? 2'($urandom_range(3)) : 2'b11;
      step(v, w[0], w[1], k, run);
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule